// File: doc/BRIEF.md
# Pixel Channel Pack Unpack Unit

This block converts between four independent 32-bit colour channel values and one packed pixel word of up to 128 bits. The layout of the packed word comes entirely from four per-channel bit widths. Channel 0 (red) sits at bit 0. Each later channel starts where the one before it ends, so its offset is the sum of the widths of the lower channels. A width of zero means the channel is not stored.

In the store direction the block saturates each integer channel to the range its width can hold. For signed formats it then cuts the result to the field width, and it places every field into the packed word. In the load direction it pulls each field out of the packed word, zero- or sign-extends it to 32 bits, and supplies constant values for channels that are not stored. A layout that makes a field straddle a 32-bit word boundary, or that gives any width above 32, is rejected. The result goes through one register stage, so it appears one cycle after the request.

Top module: `chan_pack_unit`

## Requirements
- R1: While reset is asserted, and directly after it, `o_valid`, `o_err` and `o_data` are all zero.
- R2: A request with `i_valid` high is answered exactly one cycle later with `o_valid` high. `o_data` and `o_err` change only in the cycle after an accepted request and hold their values otherwise.
- R3: Store (`i_store`=1). Channel c (c=0..3, taken from `i_data[32c+31:32c]`, width `i_wid[6c+5:6c]`) occupies packed bits starting at the sum of the widths of channels 0..c-1. Packed bits that no present channel covers are zero, and a channel of width 0 contributes nothing.
- R4: Unsigned store (`i_signed`=0). The channel value is read as an unsigned 32-bit number and limited to at most 2^w-1 before packing.
- R5: Signed store (`i_signed`=1). The channel value is read as two's complement and limited to [-2^(w-1), 2^(w-1)-1]. The field then holds the low w bits of the limited value.
- R6: Unsigned load (`i_store`=0, `i_signed`=0). Each present channel returns its field zero-extended to 32 bits in `o_data[32c+31:32c]`.
- R7: Signed load. Each present channel returns its field sign-extended from bit w-1 to 32 bits.
- R8: Load with a channel width of 0 returns 0 for channels 0, 1 and 2 and returns 1 for channel 3.
- R9: When any width exceeds 32, or a present field would cross a 32-bit word boundary, `o_err` is 1 and `o_data` is all zero. Otherwise `o_err` is 0.
- R10: A width-32 channel on a word-aligned offset passes its 32-bit value unchanged in both directions and both signedness modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| i_valid | input | 1 | Request strobe |
| i_store | input | 1 | 1: pack channels into a word, 0: unpack a word into channels |
| i_signed | input | 1 | 1: channels are two's complement, 0: unsigned |
| i_wid | input | 24 | Four 6-bit channel widths, channel 0 in the low bits |
| i_data | input | 128 | Channels (store) or packed word (load) |
| o_valid | output | 1 | Result strobe, one cycle after `i_valid` |
| o_data | output | 128 | Packed word (store) or channels (load) |
| o_err | output | 1 | Layout rejected; data forced to zero |

## Verification
The bench aims at the edges of saturation. These are the values 0x80000000, 0x7FFFFFFF, 0xFFFFFFFF, one-bit signed fields and width-32 fields. If the limit were computed off by one bit, or the comparison ignored signedness, the packed field would wrap instead of saturating. On load it drives fields whose top bit is set in both modes. A wrong choice between arithmetic and logical right shift shows up as ones or zeros in the upper bits. It sends layouts that end exactly on a word boundary and layouts that cross one by a single bit, so an off-by-one in the crossing test either rejects good layouts or lets neighbouring fields corrupt each other. It also checks which default lands in an absent alpha channel, and that results are held between requests.

// File: rtl/chan_pack_pkg.sv
package chan_pack_pkg;
   typedef enum logic {
      XFER_LOAD  = 1'b0,
      XFER_STORE = 1'b1
   } xfer_dir_e;
endpackage

// File: rtl/chan_layout.sv
// Derives per-channel offsets from the widths and rejects bad layouts.
module chan_layout #(
   parameter int N_CH   = 4,
   parameter int CHAN_W = 32,
   parameter int WID_W  = 6,
   parameter int SH_W   = 8
) (
   input  logic [N_CH*WID_W-1:0] wid,
   output logic [N_CH*SH_W-1:0]  shift,
   output logic [N_CH-1:0]       present,
   output logic                  bad
);
   localparam int LOG_CW = $clog2(CHAN_W);

   always_comb begin
      logic [SH_W-1:0]  acc;
      logic [WID_W-1:0] w;
      logic [SH_W-1:0]  fit;
      acc     = '0;
      bad     = 1'b0;
      shift   = '0;
      present = '0;
      for (int c = 0; c < N_CH; c++) begin
         w = wid[c*WID_W +: WID_W];
         shift[c*SH_W +: SH_W] = acc;
         present[c] = (w != '0);
         fit = SH_W'(acc[LOG_CW-1:0]) + SH_W'(w);
         if (SH_W'(w) > SH_W'(CHAN_W)) begin
            bad = 1'b1;
         end else if (present[c] &&
                      ((fit > SH_W'(CHAN_W)) || ((acc >> LOG_CW) >= SH_W'(N_CH)))) begin
            bad = 1'b1;
         end
         acc = acc + SH_W'(w);
      end
   end
endmodule

// File: rtl/chan_store_lane.sv
// Saturates one channel to its field width (right-aligned result).
module chan_store_lane #(
   parameter int CHAN_W = 32,
   parameter int WID_W  = 6
) (
   input  logic [CHAN_W-1:0] val,
   input  logic [WID_W-1:0]  w,
   input  logic              sgn,
   output logic [CHAN_W-1:0] field
);
   localparam logic [WID_W:0] CW_L = (WID_W+1)'(CHAN_W);

   logic [CHAN_W:0]   umax;
   logic [CHAN_W-1:0] smax;
   logic [CHAN_W-1:0] smin;
   logic [WID_W:0]    w_e;

   always_comb begin
      w_e  = {1'b0, w};
      umax = {1'b0, {CHAN_W{1'b1}}} >> (CW_L - w_e);
      smax = {CHAN_W{1'b1}} >> (CW_L - w_e + (WID_W+1)'(1));
      smin = ~smax;
      if (w == '0) begin
         field = '0;
      end else if (sgn) begin
         if ($signed(val) > $signed(smax))      field = smax;
         else if ($signed(val) < $signed(smin)) field = smin;
         else                                   field = val;
         field = field & umax[CHAN_W-1:0];
      end else begin
         if ({1'b0, val} > umax) field = umax[CHAN_W-1:0];
         else                    field = val;
      end
   end
endmodule

// File: rtl/chan_load_lane.sv
// Extracts one channel from the packed word: left shift, then right shift.
module chan_load_lane #(
   parameter int                N_CH    = 4,
   parameter int                CHAN_W  = 32,
   parameter int                WID_W   = 6,
   parameter int                SH_W    = 8,
   parameter logic [CHAN_W-1:0] DEF_VAL = '0
) (
   input  logic [N_CH*CHAN_W-1:0] data,
   input  logic [WID_W-1:0]       w,
   input  logic [SH_W-1:0]        sh,
   input  logic                   sgn,
   output logic [CHAN_W-1:0]      val
);
   localparam int             LOG_CW = $clog2(CHAN_W);
   localparam int             IDX_W  = SH_W - LOG_CW;
   localparam logic [WID_W:0] CW_L   = (WID_W+1)'(CHAN_W);

   logic [IDX_W-1:0]  idx;
   logic [CHAN_W-1:0] word;
   logic [CHAN_W-1:0] tmp;
   logic [WID_W:0]    lsh;
   logic [WID_W:0]    rsh;

   assign idx = sh[SH_W-1:LOG_CW];

   always_comb begin
      word = '0;
      for (int k = 0; k < N_CH; k++) begin
         if (IDX_W'(k) == idx) word = data[k*CHAN_W +: CHAN_W];
      end
      lsh = CW_L - (WID_W+1)'(sh[LOG_CW-1:0]) - {1'b0, w};
      rsh = CW_L - {1'b0, w};
      tmp = word << lsh;
      if (w == '0)  val = DEF_VAL;
      else if (sgn) val = $signed(tmp) >>> rsh;
      else          val = tmp >> rsh;
   end
endmodule

// File: rtl/chan_pack_unit.sv
module chan_pack_unit #(
   parameter int N_CH   = 4,
   parameter int CHAN_W = 32,
   parameter int WID_W  = $clog2(CHAN_W) + 1,
   parameter int TOT_W  = N_CH * CHAN_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   i_valid,
   input  logic                   i_store,
   input  logic                   i_signed,
   input  logic [N_CH*WID_W-1:0]  i_wid,
   input  logic [TOT_W-1:0]       i_data,
   output logic                   o_valid,
   output logic [TOT_W-1:0]       o_data,
   output logic                   o_err
);
   import chan_pack_pkg::*;

   localparam int SH_W = $clog2(N_CH * CHAN_W) + 1;

   if (CHAN_W < 2 || (1 << $clog2(CHAN_W)) != CHAN_W) begin : g_bad_cw
      $error("CHAN_W must be a power of two of at least 2");
   end
   if (N_CH < 1) begin : g_bad_nch
      $error("N_CH must be at least 1");
   end
   if (TOT_W != N_CH * CHAN_W) begin : g_bad_tot
      $error("TOT_W must equal N_CH*CHAN_W");
   end
   if (WID_W < $clog2(CHAN_W) + 1) begin : g_bad_wid
      $error("WID_W too narrow to encode a full channel width");
   end

   xfer_dir_e              dir;
   logic [N_CH*SH_W-1:0]   shift;
   logic [N_CH-1:0]        present;
   logic                   bad;
   logic [TOT_W-1:0]       st_fields;
   logic [TOT_W-1:0]       ld_vals;
   logic [TOT_W-1:0]       packed_w;
   logic [TOT_W-1:0]       result;

   assign dir = xfer_dir_e'(i_store);

   chan_layout #(.N_CH(N_CH), .CHAN_W(CHAN_W), .WID_W(WID_W), .SH_W(SH_W)) u_layout (
      .wid     (i_wid),
      .shift   (shift),
      .present (present),
      .bad     (bad)
   );

   for (genvar c = 0; c < N_CH; c++) begin : g_lane
      localparam logic [CHAN_W-1:0] DEF = (c == N_CH - 1) ? CHAN_W'(1) : '0;

      chan_store_lane #(.CHAN_W(CHAN_W), .WID_W(WID_W)) u_st (
         .val   (i_data[c*CHAN_W +: CHAN_W]),
         .w     (i_wid[c*WID_W +: WID_W]),
         .sgn   (i_signed),
         .field (st_fields[c*CHAN_W +: CHAN_W])
      );

      chan_load_lane #(.N_CH(N_CH), .CHAN_W(CHAN_W), .WID_W(WID_W), .SH_W(SH_W),
                       .DEF_VAL(DEF)) u_ld (
         .data (i_data),
         .w    (i_wid[c*WID_W +: WID_W]),
         .sh   (shift[c*SH_W +: SH_W]),
         .sgn  (i_signed),
         .val  (ld_vals[c*CHAN_W +: CHAN_W])
      );
   end

   always_comb begin
      packed_w = '0;
      for (int c = 0; c < N_CH; c++) begin
         if (present[c]) begin
            packed_w = packed_w |
                       (TOT_W'(st_fields[c*CHAN_W +: CHAN_W]) << shift[c*SH_W +: SH_W]);
         end
      end
      if (bad)                    result = '0;
      else if (dir == XFER_STORE) result = packed_w;
      else                        result = ld_vals;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o_valid <= 1'b0;
         o_data  <= '0;
         o_err   <= 1'b0;
      end else begin
         o_valid <= i_valid;
         if (i_valid) begin
            o_data <= result;
            o_err  <= bad;
         end
      end
   end
endmodule

// File: rtl/chan_pack_chk.sv
module chan_pack_chk #(
   parameter int N_CH   = 4,
   parameter int CHAN_W = 32,
   parameter int WID_W  = 6,
   parameter int TOT_W  = 128
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  i_valid,
   input logic                  i_store,
   input logic                  i_signed,
   input logic [N_CH*WID_W-1:0] i_wid,
   input logic [TOT_W-1:0]      i_data,
   input logic                  o_valid,
   input logic [TOT_W-1:0]      o_data,
   input logic                  o_err
);
   assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (o_valid == $past(i_valid)));

   assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(i_valid)) |-> ($stable(o_data) && $stable(o_err)));

   assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      o_err |-> (o_data == '0));

   assert_empty_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(i_valid && i_store && (i_wid == '0))) |-> ((o_data == '0) && !o_err));

   assert_alpha_default_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(i_valid && !i_store && (i_wid[N_CH*WID_W-1 -: WID_W] == '0)) && !o_err)
      |-> (o_data[TOT_W-1 -: CHAN_W] == CHAN_W'(1)));
endmodule

bind chan_pack_unit chan_pack_chk #(
   .N_CH(N_CH), .CHAN_W(CHAN_W), .WID_W(WID_W), .TOT_W(TOT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_store(i_store),
   .i_signed(i_signed), .i_wid(i_wid), .i_data(i_data),
   .o_valid(o_valid), .o_data(o_data), .o_err(o_err)
);

// File: tb/tb_chan_pack_unit.sv
module tb_chan_pack_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         i_valid = 1'b0;
   logic         i_store = 1'b0;
   logic         i_signed = 1'b0;
   logic [23:0]  i_wid = '0;
   logic [127:0] i_data = '0;
   logic         o_valid;
   logic [127:0] o_data;
   logic         o_err;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [127:0] last_exp = '0;
   logic         last_err = 1'b0;

   always #5 clk = ~clk;

   chan_pack_unit dut (
      .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_store(i_store),
      .i_signed(i_signed), .i_wid(i_wid), .i_data(i_data),
      .o_valid(o_valid), .o_data(o_data), .o_err(o_err)
   );

   function automatic int wof(logic [23:0] wd, int c);
      return int'(wd[c*6 +: 6]);
   endfunction

   function automatic bit m_err(logic [23:0] wd);
      int sh = 0;
      bit e = 0;
      for (int c = 0; c < 4; c++) begin
         int w = wof(wd, c);
         if (w > 32) e = 1;
         else if (w != 0 && ((sh % 32) + w > 32)) e = 1;
         sh += w;
      end
      return e;
   endfunction

   function automatic logic [127:0] m_store(logic [23:0] wd, bit sg, logic [127:0] d);
      logic [127:0] r = '0;
      int sh = 0;
      for (int c = 0; c < 4; c++) begin
         int w = wof(wd, c);
         longint f;
         if (w != 0) begin
            if (sg) begin
               longint v  = longint'($signed(d[c*32 +: 32]));
               longint hi = (longint'(1) << (w - 1)) - 1;
               longint lo = -hi - 1;
               f = (v > hi) ? hi : ((v < lo) ? lo : v);
            end else begin
               longint v  = longint'({32'b0, d[c*32 +: 32]});
               longint hi = (longint'(1) << w) - 1;
               f = (v > hi) ? hi : v;
            end
            for (int b = 0; b < w; b++) r[sh + b] = f[b];
         end
         sh += w;
      end
      return r;
   endfunction

   function automatic logic [127:0] m_load(logic [23:0] wd, bit sg, logic [127:0] d);
      logic [127:0] r = '0;
      int sh = 0;
      for (int c = 0; c < 4; c++) begin
         int w = wof(wd, c);
         logic [31:0] f = '0;
         if (w == 0) begin
            f = (c == 3) ? 32'd1 : 32'd0;
         end else begin
            for (int b = 0; b < w; b++) f[b] = d[sh + b];
            if (sg && f[w-1]) for (int b = w; b < 32; b++) f[b] = 1'b1;
         end
         r[c*32 +: 32] = f;
         sh += w;
      end
      return r;
   endfunction

   function automatic logic [23:0] mkw(int r, int g, int b, int a);
      return {6'(a), 6'(b), 6'(g), 6'(r)};
   endfunction

   task automatic apply(string tag, bit st, bit sg, logic [23:0] wd, logic [127:0] d);
      logic [127:0] exp_d;
      bit exp_e;
      exp_e = m_err(wd);
      exp_d = exp_e ? 128'd0 : (st ? m_store(wd, sg, d) : m_load(wd, sg, d));
      @(negedge clk);
      i_valid = 1'b1; i_store = st; i_signed = sg; i_wid = wd; i_data = d;
      @(negedge clk);
      i_valid = 1'b0;
      n_chk++;
      if (o_valid !== 1'b1 || o_data !== exp_d || o_err !== exp_e) begin
         n_bad++;
         $display("FAIL %s: valid=%b err=%b data=%h expected valid=1 err=%b data=%h",
                  tag, o_valid, o_err, o_data, exp_e, exp_d);
      end
      last_exp = exp_d;
      last_err = exp_e;
   endtask

   task automatic idle_check();
      i_data = {$urandom, $urandom, $urandom, $urandom};
      i_wid  = 24'($urandom);
      @(negedge clk);
      n_chk++;
      if (o_valid !== 1'b0 || o_data !== last_exp || o_err !== last_err) begin
         n_bad++;
         $display("FAIL R2 hold: valid=%b err=%b data=%h expected valid=0 err=%b data=%h",
                  o_valid, o_err, o_data, last_err, last_exp);
      end
   endtask

   function automatic logic [31:0] pick_val();
      case ($urandom % 6)
         0: return 32'h8000_0000;
         1: return 32'h7FFF_FFFF;
         2: return 32'hFFFF_FFFF;
         3: return 32'h0;
         4: return 32'($urandom % 600) - 32'd300;
         default: return $urandom;
      endcase
   endfunction

   function automatic logic [23:0] pick_wid();
      case ($urandom % 8)
         0: return mkw(8, 8, 8, 8);
         1: return mkw(16, 16, 16, 16);
         2: return mkw(10, 10, 10, 2);
         3: return mkw(11, 11, 10, 0);
         4: return mkw(5, 6, 5, 0);
         5: return mkw(32, 32, 32, 32);
         6: return mkw(int'($urandom % 33), int'($urandom % 33),
                       int'($urandom % 33), int'($urandom % 33));
         default: return mkw(1, 7, 16, 8);
      endcase
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      n_chk++;
      if (o_valid !== 1'b0 || o_data !== '0 || o_err !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 reset: valid=%b err=%b data=%h expected 0 0 0", o_valid, o_err, o_data);
      end
      rst_n = 1'b1;
      @(negedge clk);
      n_chk++;
      if (o_valid !== 1'b0 || o_data !== '0 || o_err !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 after reset: valid=%b err=%b data=%h expected 0 0 0", o_valid, o_err, o_data);
      end

      // directed corner cases
      apply("R4", 1, 0, mkw(8, 8, 8, 8), {32'hFFFF_FFFF, 32'd0, 32'd255, 32'd300});
      apply("R5", 1, 1, mkw(8, 8, 8, 8), {32'h8000_0000, 32'h7FFF_FFFF, -32'sd200, -32'sd1});
      apply("R5", 1, 1, mkw(1, 1, 30, 0), {32'd5, 32'd7, -32'sd9, 32'd1});
      apply("R3", 1, 0, mkw(5, 6, 5, 0), {32'd9, 32'd3, 32'd40, 32'd17});
      apply("R3", 1, 0, mkw(0, 0, 0, 0), {4{32'hDEAD_BEEF}});
      idle_check();
      apply("R6", 0, 0, mkw(10, 10, 10, 2), {96'h0, 32'hFFFF_FFFF});
      apply("R7", 0, 1, mkw(10, 10, 10, 2), {96'h0, 32'hA020_0600});
      apply("R7", 0, 1, mkw(1, 7, 16, 8), {96'h0, 32'h8001_80FF});
      apply("R8", 0, 0, mkw(11, 11, 10, 0), {4{32'hFFFF_FFFF}});
      apply("R8", 0, 1, mkw(0, 0, 0, 0), {4{32'h1234_5678}});
      idle_check();
      apply("R9", 1, 0, mkw(20, 20, 0, 0), {4{32'h0000_0FFF}});
      apply("R9", 0, 1, mkw(16, 17, 0, 0), {4{32'hFFFF_FFFF}});
      apply("R9", 0, 0, mkw(33, 0, 0, 0), {4{32'h5555_5555}});
      apply("R9", 1, 0, mkw(31, 0, 32, 1), {4{32'h1}});
      idle_check();
      apply("R10", 1, 1, mkw(32, 32, 32, 32), {32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h1234_5678});
      apply("R10", 0, 1, mkw(32, 32, 32, 32), {32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h1234_5678});
      apply("R10", 1, 0, mkw(32, 0, 32, 0), {32'h1, 32'hCAFE_F00D, 32'h9, 32'hFFFF_FFFF});

      // constrained random mix (store R3/R4/R5, load R6/R7/R8, error R9)
      for (int n = 0; n < 400; n++) begin
         logic [23:0]  wd = pick_wid();
         logic [127:0] d  = {pick_val(), pick_val(), pick_val(), pick_val()};
         bit st = 1'($urandom);
         bit sg = 1'($urandom);
         if (!st) d = {$urandom, $urandom, $urandom, $urandom};
         apply(st ? (sg ? "R5 random" : "R4 random") : (sg ? "R7 random" : "R6 random"),
               st, sg, wd, d);
         if (n % 37 == 0) idle_check();
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule